// File: doc/BRIEF.md
# DDR3 Calibration Register Readout

This block models the calibration readout path of a DDR3 memory device. A mode-register write to the third mode register carries two fields: a switch that turns calibration readout on or off, and a two-bit location select. Location 0 holds a fixed alternating training pattern. The other three locations are reserved, and reading one of them returns zeros and raises a sticky error flag.

While readout is on, a read command plays the selected location back on a single data lane. It sends one beat per clock, starting a fixed number of cycles after the command. A full burst sends all eight beats in order 0 to 7. A chopped burst sends four beats, and column address bit 2 picks either the lower half (beats 0 to 3) or the upper half (beats 4 to 7). Beat i is bit i of the location, with beat 0 as the least significant bit. The block accepts one read at a time. A mode-register write that arrives while a read is in progress is held back and applied once the burst has finished.

Top module: `mpr_readout`

## Requirements
- R1: After reset, `dq_valid`, `dq_bit` and `rsv_err` are 0 and calibration readout is off.
- R2: While readout is off, a read command causes no output: `dq_valid` stays 0.
- R3: A read sampled at clock edge k shows its first beat after edge k+RD_LAT. Beats follow on consecutive cycles, and `dq_valid` is high for exactly the length of the burst.
- R4: With `rd_bc4`=0 (full burst) from location 0, eight beats are sent with values 0,1,0,1,0,1,0,1. Beat i is bit i of the pattern 8'b10101010, LSB first. `rd_col2` has no effect on a full burst.
- R5: With `rd_bc4`=1 and `rd_col2`=0, four beats are sent: beats 0..3 with values 0,1,0,1.
- R6: With `rd_bc4`=1 and `rd_col2`=1, four beats are sent: beats 4..7 with values 0,1,0,1.
- R7: A read of a reserved location (`mrs_loc` 01, 10 or 11) runs a burst of the normal length with all beats 0. It also sets `rsv_err`, which stays at 1 until reset.
- R8: A read command that arrives while an earlier read is still waiting or sending is ignored.
- R9: A mode-register write (`mrs_valid`) that arrives while a read is waiting or sending does not change the burst in progress. It takes effect after the last beat. If several such writes arrive, the newest one wins. A read accepted once the block is idle again uses the held value.
- R10: When a mode-register write and a read arrive in the same idle cycle, the read uses the setting in force before that write, and the write governs later reads.
- R11: `dq_bit` is 0 whenever `dq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mrs_valid | input | 1 | Mode-register write strobe for the calibration register |
| mrs_mpr_en | input | 1 | Readout on (1) or off (0) |
| mrs_loc | input | 2 | Location select; 00 is the training pattern, other values are reserved |
| rd_valid | input | 1 | Read command strobe |
| rd_bc4 | input | 1 | 1 = chopped burst of four beats, 0 = full burst of eight beats |
| rd_col2 | input | 1 | Column address bit 2; picks the upper half for a chopped burst |
| dq_valid | output | 1 | High while a beat is on `dq_bit` |
| dq_bit | output | 1 | Beat data |
| rsv_err | output | 1 | Sticky flag: a reserved location was read |

## Verification
Two events can land in the same cycle: a mode-register write, and a read command or a burst in flight. The bench provokes this in three ways. It issues a write and a read in one idle cycle. It sends two writes in the middle of a burst. It places a read in the very cycle that a held write is due to be applied. A behavioural model decides which setting each read must use and predicts `dq_valid`, `dq_bit` and `rsv_err` for every cycle. Any disagreement in stream length, data or error flag counts as a failure.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int LOC_W = 2;
  localparam logic [LOC_W-1:0] LOC_CAL = '0;

  typedef struct packed {
    logic             en;
    logic [LOC_W-1:0] loc;
  } mr3_cfg_t;
endpackage

// File: rtl/mpr_mr3_cfg.sv
module mpr_mr3_cfg
  import mpr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  mr3_cfg_t  wr_cfg,
  input  logic      hold,
  output mr3_cfg_t  eff_cfg
);
  mr3_cfg_t cfg_q, pend_q;
  logic     pend_v;

  // a held write is visible to a read in the cycle it is due to apply
  assign eff_cfg = pend_v ? pend_q : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else if (!hold) begin
      if (wr)          cfg_q <= wr_cfg;
      else if (pend_v) cfg_q <= pend_q;
      pend_v <= 1'b0;
    end else if (wr) begin
      pend_q <= wr_cfg;
      pend_v <= 1'b1;
    end
  end

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(cfg_q));
  p_cfg_queued_r9: assert property (@(posedge clk) disable iff (rst)
    hold && wr |=> pend_v && pend_q == $past(wr_cfg));
endmodule

// File: rtl/mpr_pattern_rom.sv
module mpr_pattern_rom
  import mpr_pkg::*;
#(
  parameter int BEATS = 8,
  parameter logic [BEATS-1:0] CAL_PATTERN = {(BEATS/2){2'b10}}
)(
  input  logic [LOC_W-1:0]         loc,
  input  logic [$clog2(BEATS)-1:0] beat,
  output logic                     bit_o
);
  localparam int NUM_LOC = 1 << LOC_W;

  logic [BEATS-1:0] loc_pat [NUM_LOC];

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
    if (g == int'(LOC_CAL)) begin : g_cal
      assign loc_pat[g] = CAL_PATTERN;
    end else begin : g_rsv
      assign loc_pat[g] = '0;
    end
  end

  assign bit_o = loc_pat[loc][beat];
endmodule

// File: rtl/mpr_burst_seq.sv
module mpr_burst_seq
  import mpr_pkg::*;
#(
  parameter int BEATS  = 8,
  parameter int RD_LAT = 4
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     start_bc4,
  input  logic                     start_col2,
  input  logic [LOC_W-1:0]         start_loc,
  input  logic                     rom_bit,
  output logic                     busy,
  output logic [$clog2(BEATS)-1:0] beat_idx,
  output logic [LOC_W-1:0]         cur_loc,
  output logic                     dq_valid,
  output logic                     dq_bit
);
  localparam int BW   = $clog2(BEATS);
  localparam int HALF = BEATS / 2;
  localparam int PW   = $clog2(RD_LAT + BEATS + 1);

  logic [PW-1:0] pos_q, rel, last_rel, run_q;
  logic [BW-1:0] base_q;
  logic          bc4_q, in_data, last_beat;

  assign rel       = pos_q - PW'(RD_LAT - 1);
  assign in_data   = pos_q >= PW'(RD_LAT - 1);
  assign last_rel  = bc4_q ? PW'(HALF - 1) : PW'(BEATS - 1);
  assign last_beat = in_data && (rel == last_rel);
  assign beat_idx  = base_q + rel[BW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      pos_q    <= '0;
      bc4_q    <= 1'b0;
      base_q   <= '0;
      cur_loc  <= '0;
      dq_valid <= 1'b0;
      dq_bit   <= 1'b0;
    end else if (busy) begin
      pos_q    <= pos_q + 1'b1;
      dq_valid <= in_data;
      dq_bit   <= in_data & rom_bit;
      if (last_beat) busy <= 1'b0;
    end else begin
      dq_valid <= 1'b0;
      dq_bit   <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        pos_q   <= '0;
        bc4_q   <= start_bc4;
        base_q  <= (start_bc4 && start_col2) ? BW'(HALF) : '0;
        cur_loc <= start_loc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           run_q <= '0;
    else if (dq_valid) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !dq_valid |-> !dq_bit);
  p_burst_len_r3: assert property (@(posedge clk) disable iff (rst)
    dq_valid |-> run_q < PW'(BEATS));
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || pos_q == $past(pos_q) + 1'b1));
endmodule

// File: rtl/mpr_readout.sv
module mpr_readout
  import mpr_pkg::*;
#(
  parameter int BEATS  = 8,
  parameter int RD_LAT = 4
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             mrs_valid,
  input  logic             mrs_mpr_en,
  input  logic [LOC_W-1:0] mrs_loc,
  input  logic             rd_valid,
  input  logic             rd_bc4,
  input  logic             rd_col2,
  output logic             dq_valid,
  output logic             dq_bit,
  output logic             rsv_err
);
  localparam int BW = $clog2(BEATS);

  mr3_cfg_t         wr_cfg, eff_cfg;
  logic             busy, accept, rom_bit;
  logic [BW-1:0]    beat_idx;
  logic [LOC_W-1:0] cur_loc;

  assign wr_cfg = '{en: mrs_mpr_en, loc: mrs_loc};
  assign accept = rd_valid && !busy && eff_cfg.en;

  mpr_mr3_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr      (mrs_valid),
    .wr_cfg  (wr_cfg),
    .hold    (busy),
    .eff_cfg (eff_cfg)
  );

  mpr_pattern_rom #(.BEATS(BEATS)) u_rom (
    .loc   (cur_loc),
    .beat  (beat_idx),
    .bit_o (rom_bit)
  );

  mpr_burst_seq #(.BEATS(BEATS), .RD_LAT(RD_LAT)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .start_bc4  (rd_bc4),
    .start_col2 (rd_col2),
    .start_loc  (eff_cfg.loc),
    .rom_bit    (rom_bit),
    .busy       (busy),
    .beat_idx   (beat_idx),
    .cur_loc    (cur_loc),
    .dq_valid   (dq_valid),
    .dq_bit     (dq_bit)
  );

  always_ff @(posedge clk) begin
    if (rst)                                  rsv_err <= 1'b0;
    else if (accept && eff_cfg.loc != LOC_CAL) rsv_err <= 1'b1;
  end

  p_off_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !busy && !eff_cfg.en |=> !busy);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    rsv_err |=> rsv_err);
  p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rsv_err) |-> $past(rd_valid));
  p_rsv_zero_r7: assert property (@(posedge clk) disable iff (rst)
    dq_valid && cur_loc != LOC_CAL |-> !dq_bit);
endmodule

// File: tb/mpr_readout_tb_top.sv
module mpr_readout_tb_top;
  localparam int LAT = 4;

  logic       clk = 1'b0, rst = 1'b1;
  logic       mrs_valid = 1'b0, mrs_mpr_en = 1'b0, rd_valid = 1'b0;
  logic       rd_bc4 = 1'b0, rd_col2 = 1'b0;
  logic [1:0] mrs_loc = 2'b00;
  logic       dq_valid, dq_bit, rsv_err;

  int    total = 0, bad = 0, edge_n = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // reference model state
  bit       exp_v [int];
  bit       exp_b [int];
  bit       m_en = 0, p_v = 0, p_en = 0, m_err = 0;
  bit [1:0] m_loc = 0, p_loc = 0;
  int       last_edge = -100;

  always #10 clk = ~clk;

  mpr_readout #(.BEATS(8), .RD_LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .mrs_valid(mrs_valid), .mrs_mpr_en(mrs_mpr_en),
    .mrs_loc(mrs_loc), .rd_valid(rd_valid), .rd_bc4(rd_bc4), .rd_col2(rd_col2),
    .dq_valid(dq_valid), .dq_bit(dq_bit), .rsv_err(rsv_err)
  );

  always @(posedge clk) begin
    bit busy, e_en;
    bit [1:0] e_loc;
    edge_n++;
    if (rst) begin
      m_en = 0; m_loc = 0; p_v = 0; m_err = 0; last_edge = -100;
    end else begin
      busy  = edge_n <= last_edge;
      e_en  = p_v ? p_en : m_en;
      e_loc = p_v ? p_loc : m_loc;
      if (!busy && rd_valid && e_en) begin
        int n, s;
        n = rd_bc4 ? 4 : 8;
        s = (rd_bc4 && rd_col2) ? 4 : 0;
        for (int b = 0; b < n; b++) begin
          exp_v[edge_n + LAT + b] = 1;
          exp_b[edge_n + LAT + b] = (e_loc == 0) ? bit'((s + b) % 2) : 1'b0;
        end
        last_edge = edge_n + LAT + n - 1;
        if (e_loc != 0) m_err = 1;
      end
      if (!busy) begin
        if (mrs_valid) begin m_en = mrs_mpr_en; m_loc = mrs_loc; end
        else if (p_v) begin m_en = p_en; m_loc = p_loc; end
        p_v = 0;
      end else if (mrs_valid) begin
        p_v = 1; p_en = mrs_mpr_en; p_loc = mrs_loc;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s at edge %0d: actual=%0d expected=%0d", req, what, edge_n, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int ev, eb;
      ev = exp_v.exists(edge_n) ? int'(exp_v[edge_n]) : 0;
      eb = exp_b.exists(edge_n) ? int'(exp_b[edge_n]) : 0;
      chk(cur_req, "dq_valid", int'(dq_valid), ev);
      chk(cur_req, "dq_bit", int'(dq_bit), eb);
      chk(cur_req, "rsv_err", int'(rsv_err), int'(m_err));
    end
  end

  task automatic cyc(bit mrs, bit en, bit [1:0] loc, bit rd, bit bc4, bit col2);
    @(negedge clk);
    mrs_valid = mrs; mrs_mpr_en = en; mrs_loc = loc;
    rd_valid = rd; rd_bc4 = bc4; rd_col2 = col2;
    @(negedge clk);
    mrs_valid = 0; rd_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20ns * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    chk("R1", "reset dq_valid", int'(dq_valid), 0);
    chk("R1", "reset rsv_err", int'(rsv_err), 0);
    cur_req = "R2"; cyc(0, 0, 0, 1, 0, 0); idle(14);
    cyc(0, 0, 0, 1, 1, 1); idle(14);
    cur_req = "R3"; cyc(1, 1, 2'b00, 0, 0, 0); cyc(0, 0, 0, 1, 0, 0); idle(14);
    cur_req = "R4"; cyc(0, 0, 0, 1, 0, 1); idle(14);
    cur_req = "R5"; cyc(0, 0, 0, 1, 1, 0); idle(10);
    cur_req = "R6"; cyc(0, 0, 0, 1, 1, 1); idle(10);
    cur_req = "R8"; cyc(0, 0, 0, 1, 0, 0); cyc(0, 0, 0, 1, 1, 1);
    cyc(0, 0, 0, 1, 1, 0); idle(14);
    // deferred write: two writes mid-burst, newest (off) wins
    cur_req = "R9"; cyc(0, 0, 0, 1, 0, 0); cyc(1, 1, 2'b10, 0, 0, 0);
    cyc(1, 0, 2'b00, 0, 0, 0); idle(14);
    cyc(0, 0, 0, 1, 0, 0); idle(14);
    // same-cycle write and read while idle: read uses old (off) setting
    cur_req = "R10"; cyc(1, 1, 2'b00, 1, 0, 0); idle(14);
    cyc(1, 0, 2'b00, 1, 1, 1); idle(10);
    cyc(0, 0, 0, 1, 0, 0); idle(14);
    // read lands in the cycle a held write is applied
    cur_req = "R9"; cyc(1, 1, 2'b00, 0, 0, 0); cyc(0, 0, 0, 1, 1, 0);
    cyc(1, 1, 2'b01, 0, 0, 0);
    idle(LAT);
    cur_req = "R7"; cyc(0, 0, 0, 1, 0, 0); idle(14);
    chk("R7", "sticky rsv_err", int'(rsv_err), 1);
    cur_req = "R11"; cyc(1, 1, 2'b00, 0, 0, 0); cyc(0, 0, 0, 1, 1, 1); idle(12);
    chk("R7", "rsv_err still set", int'(rsv_err), 1);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule